// File: doc/BRIEF.md
# 64-Bit Linear Address Former

This block turns the operands of one memory reference into a linear address for a core that runs both a 64-bit mode and the older 32-bit modes. Each request carries a base register value, an index value with a scale code, a signed 32-bit displacement, a segment base, an address-size code, the execution mode and three flags that describe how the reference touches the stack. The block adds the parts, cuts the sum down to the address size, places the segment base on top according to the mode, and checks the result for canonical form in 64-bit mode. The output is the linear address and a 2-bit fault code that tells a stack fault apart from a general-protection fault. Privilege, paging and limit checks are done elsewhere.

Requests enter through a valid/ready handshake and results leave through another. A request is taken on a rising edge where `in_valid` and `in_ready` are both high, and its result is presented with `out_valid` on the next cycle. The result register holds steady while `out_ready` is low. `in_ready` is high whenever the result register is empty or is being emptied in the same cycle, so one request per cycle flows when the consumer never stalls. While the consumer stalls, the producer must hold its request and wait.

Top module: `lin_addr_former`

## Requirements
- R1: The index value is multiplied by 1, 2, 4 or 8 for scale codes 0, 1, 2 and 3. The 32-bit displacement is sign-extended to 64 bits before it is added to base and scaled index.
- R2: With 64-bit addressing (mode64=1 and size code 2 or 3), the effective address is the full sum taken modulo 2^64.
- R3: Size code 1 keeps the low 32 bits of the sum and size code 0 keeps the low 16 bits. Both are zero-extended to 64 bits.
- R4: In 64-bit mode with `seg_fsgs`=1, the segment base is added after truncation, and that 64-bit sum is not truncated.
- R5: In 64-bit mode with `seg_fsgs`=0, the segment base has no effect on the address.
- R6: In 64-bit mode an address whose bits 63:48 do not all equal bit 47 is faulted. It gets code 01 (general protection) when no stack condition applies. A canonical address gets code 00.
- R7: A non-canonical address gets code 10 (stack fault) when `stack_ref`=1, or when `base_spbp`=1 and `ovr_nonss`=0. When `base_spbp`=1 and `ovr_nonss`=1 without `stack_ref`, it gets code 01. Code 11 never appears.
- R8: With mode64=0, size codes 2 and 3 act as 32-bit. The segment base is always added, and the sum wraps to 32 bits and is zero-extended.
- R9: With mode64=0 the fault code is always 00.
- R10: A result appears with `out_valid` exactly one cycle after its request is taken. It holds address and fault unchanged while `out_ready` is low. Results leave in request order, and `in_ready` = not `out_valid` or `out_ready`.
- R11: While `rst_n` is low on a clock edge, `out_valid` clears and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| scale_code | input | 2 | Index multiplier code: 1, 2, 4, 8 |
| disp_val | input | 32 | Signed displacement |
| seg_base | input | 64 | Base of the selected segment |
| seg_fsgs | input | 1 | Selected segment is one whose base applies in 64-bit mode |
| addr_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2/3 = 64-bit |
| mode64 | input | 1 | Core is in 64-bit mode |
| stack_ref | input | 1 | Implicit stack access |
| base_spbp | input | 1 | Base register is the stack or frame pointer |
| ovr_nonss | input | 1 | Segment override to a segment other than the stack segment |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 64 | Linear address |
| out_fault | output | 2 | 00 none, 01 general protection, 10 stack fault |

## Verification
The canonical fault and the late segment-base addition fall in the same result when a 32-bit address near 4 GB is added to an FS/GS-type base just under bit 47. The carry into bit 47 must then raise the fault, and a stack-pointer base with and without an override decides its kind. A back-pressure stall can also overlap a new request waiting at the input. The bench drives a gated `out_ready` pattern while requests are queued, and it judges that the held result stays stable and that the scoreboard order survives the stall.

// File: rtl/lin_addr_pkg.sv
package lin_addr_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned DISP_W = 32;
  localparam int unsigned IMPL_W = 48;

  typedef enum logic [1:0] {
    EW_16 = 2'd0,
    EW_32 = 2'd1,
    EW_64 = 2'd2
  } eff_width_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_GP    = 2'b01,
    FLT_STACK = 2'b10
  } fault_e;
endpackage

// File: rtl/lin_ea_sum.sv
module lin_ea_sum
  import lin_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DISP_W
) (
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    scale_code,
  input  logic [DW-1:0] disp_val,
  input  logic [1:0]    addr_size,
  input  logic          mode64,
  output logic [AW-1:0] ea_trunc
);
  localparam int unsigned EXT_W = AW - DW;

  logic [AW-1:0] scaled_idx;
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] raw_sum;
  eff_width_e    width_sel;

  // R1: scale code is a shift distance
  assign scaled_idx = index_val << scale_code;

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{disp_val[DW-1]}}, disp_val};
    end else begin : g_nosext
      assign disp_ext = disp_val[AW-1:0];
    end
  endgenerate

  assign raw_sum = base_val + scaled_idx + disp_ext;

  // R8: outside 64-bit mode a 64-bit size code falls back to 32 bits
  always_comb begin
    if (addr_size[1])
      width_sel = mode64 ? EW_64 : EW_32;
    else if (addr_size[0])
      width_sel = EW_32;
    else
      width_sel = EW_16;
  end

  // R2, R3: truncate to the address size and zero-extend
  always_comb begin
    ea_trunc = '0;
    unique case (width_sel)
      EW_16:   ea_trunc[15:0] = raw_sum[15:0];
      EW_32:   ea_trunc[31:0] = raw_sum[31:0];
      default: ea_trunc       = raw_sum;
    endcase
  end
endmodule

// File: rtl/lin_seg_add.sv
module lin_seg_add
  import lin_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] ea_trunc,
  input  logic [AW-1:0] seg_base,
  input  logic          seg_fsgs,
  input  logic          mode64,
  output logic [AW-1:0] lin_addr
);
  logic [AW-1:0] wide_sum;
  logic [31:0]   narrow_sum;

  assign wide_sum   = ea_trunc + seg_base;
  assign narrow_sum = ea_trunc[31:0] + seg_base[31:0];

  always_comb begin
    lin_addr = '0;
    if (mode64) begin
      // R4, R5: only FS/GS-type bases count, added after truncation
      lin_addr = seg_fsgs ? wide_sum : ea_trunc;
    end else begin
      // R8: 32-bit wrap, zero-extended
      lin_addr[31:0] = narrow_sum;
    end
  end
endmodule

// File: rtl/lin_canon_chk.sv
module lin_canon_chk
  import lin_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned VW = IMPL_W
) (
  input  logic [AW-1:0] lin_addr,
  input  logic          mode64,
  input  logic          stack_ref,
  input  logic          base_spbp,
  input  logic          ovr_nonss,
  output fault_e        fault
);
  localparam int unsigned TOP_W = AW - VW + 1;

  logic [TOP_W-1:0] top_bits;
  logic             non_canon;
  logic             stack_kind;

  assign top_bits   = lin_addr[AW-1:VW-1];
  assign non_canon  = !((&top_bits) || !(|top_bits));
  // R7: implicit stack use, or SP/BP base kept on the stack segment
  assign stack_kind = stack_ref || (base_spbp && !ovr_nonss);

  always_comb begin
    fault = FLT_NONE;
    // R6, R9: checked only in 64-bit mode
    if (mode64 && non_canon)
      fault = stack_kind ? FLT_STACK : FLT_GP;
  end
endmodule

// File: rtl/lin_addr_former.sv
module lin_addr_former
  import lin_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DISP_W,
  parameter int unsigned VW = IMPL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    scale_code,
  input  logic [DW-1:0] disp_val,
  input  logic [AW-1:0] seg_base,
  input  logic          seg_fsgs,
  input  logic [1:0]    addr_size,
  input  logic          mode64,
  input  logic          stack_ref,
  input  logic          base_spbp,
  input  logic          ovr_nonss,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_fault
);
  logic [AW-1:0] ea_trunc;
  logic [AW-1:0] lin_addr;
  fault_e        fault_c;
  logic          take;
  logic          valid_q;
  logic          mode64_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    fault_q;

  lin_ea_sum #(.AW(AW), .DW(DW)) u_sum (
    .base_val   (base_val),
    .index_val  (index_val),
    .scale_code (scale_code),
    .disp_val   (disp_val),
    .addr_size  (addr_size),
    .mode64     (mode64),
    .ea_trunc   (ea_trunc)
  );

  lin_seg_add #(.AW(AW)) u_seg (
    .ea_trunc (ea_trunc),
    .seg_base (seg_base),
    .seg_fsgs (seg_fsgs),
    .mode64   (mode64),
    .lin_addr (lin_addr)
  );

  lin_canon_chk #(.AW(AW), .VW(VW)) u_canon (
    .lin_addr  (lin_addr),
    .mode64    (mode64),
    .stack_ref (stack_ref),
    .base_spbp (base_spbp),
    .ovr_nonss (ovr_nonss),
    .fault     (fault_c)
  );

  // R10: single result stage, refilled in the cycle it drains
  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (in_ready) begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q   <= lin_addr;
      fault_q  <= fault_c;
      mode64_q <= mode64;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_fault = fault_q;

  // R10: taken request shows up next cycle
  a_r10_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R10: stalled result holds
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_fault));

  // R7: code 11 is never produced
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_fault != 2'b11);

  // R9: no fault outside 64-bit mode
  a_r9_compat_nofault: assert property (@(posedge clk) disable iff (!rst_n)
    take && !mode64 |=> out_fault == 2'b00);

  // R8: compat results stay below 4 GB
  a_r8_compat_low4g: assert property (@(posedge clk) disable iff (!rst_n)
    take && !mode64 |=> out_addr[AW-1:32] == '0);

  // R6: an unfaulted 64-bit-mode address is canonical
  a_r6_clean_is_canon: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode64_q && out_fault == 2'b00 |->
      ((&out_addr[AW-1:VW-1]) || !(|out_addr[AW-1:VW-1])));
endmodule

// File: tb/sim_lin_addr_former.sv
module sim_lin_addr_former;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [1:0]  scale_code = '0;
  logic [31:0] disp_val = '0;
  logic [63:0] seg_base = '0;
  logic        seg_fsgs = 1'b0;
  logic [1:0]  addr_size = '0;
  logic        mode64 = 1'b0;
  logic        stack_ref = 1'b0;
  logic        base_spbp = 1'b0;
  logic        ovr_nonss = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr;
  logic [1:0]  out_fault;

  int checks = 0;
  int errors = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  logic [63:0] q_addr[$];
  logic [1:0]  q_fault[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  lin_addr_former u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_val(base_val), .index_val(index_val), .scale_code(scale_code),
    .disp_val(disp_val), .seg_base(seg_base), .seg_fsgs(seg_fsgs),
    .addr_size(addr_size), .mode64(mode64), .stack_ref(stack_ref),
    .base_spbp(base_spbp), .ovr_nonss(ovr_nonss), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_fault(out_fault)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Model written from the requirement text
  task automatic model(input logic [63:0] b, input logic [63:0] ix, input logic [1:0] sc,
                       input logic [31:0] d, input logic [63:0] sg, input bit fsgs,
                       input logic [1:0] asz, input bit m64, input bit stk, input bit spbp,
                       input bit ovr, output logic [63:0] a, output logic [1:0] f);
    logic [63:0] mult, dext, sum, ea, top;
    bit canon;
    mult = 64'd1;
    for (int k = 0; k < int'(sc); k++) mult = mult * 64'd2;
    dext = d[31] ? {32'hFFFF_FFFF, d} : {32'h0, d};
    sum  = b + ix * mult + dext;
    if (m64 && asz >= 2'd2)   ea = sum;
    else if (asz == 2'd0)     ea = sum & 64'h0000_0000_0000_FFFF;
    else                      ea = sum & 64'h0000_0000_FFFF_FFFF;
    if (m64) a = fsgs ? ea + sg : ea;
    else     a = (ea + sg) & 64'h0000_0000_FFFF_FFFF;
    top = a >> 47;
    canon = (top == 64'h0) || (top == 64'h1_FFFF);
    if (!m64 || canon)               f = 2'b00;
    else if (stk || (spbp && !ovr))  f = 2'b10;
    else                             f = 2'b01;
  endtask

  // Driver: presents one request and pushes the expected result
  task automatic send(input string tag, input logic [63:0] b, input logic [63:0] ix,
                      input logic [1:0] sc, input logic [31:0] d, input logic [63:0] sg,
                      input bit fsgs, input logic [1:0] asz, input bit m64,
                      input bit stk, input bit spbp, input bit ovr);
    logic [63:0] ea_exp;
    logic [1:0]  f_exp;
    model(b, ix, sc, d, sg, fsgs, asz, m64, stk, spbp, ovr, ea_exp, f_exp);
    base_val = b; index_val = ix; scale_code = sc; disp_val = d; seg_base = sg;
    seg_fsgs = fsgs; addr_size = asz; mode64 = m64; stack_ref = stk;
    base_spbp = spbp; ovr_nonss = ovr; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q_addr.push_back(ea_exp);
    q_fault.push_back(f_exp);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Consumer readiness, changed just after each rising edge
  always @(posedge clk) begin
    #2;
    if (stall_mode) out_ready = (cyc % 4) == 3;
    else            out_ready = 1'b1;
  end

  // Monitor: pops and compares, and checks stalled results hold (R10)
  logic [63:0] held_addr;
  logic [1:0]  held_fault;
  bit          held = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      if (held) begin
        check(out_valid && out_addr == held_addr && out_fault == held_fault,
              "R10 stalled result held", out_addr, held_addr);
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin
        held = 1'b1; held_addr = out_addr; held_fault = out_fault;
      end
      if (out_valid && out_ready) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R10 unexpected result", out_addr, 64'h0);
        end else begin
          logic [63:0] ea; logic [1:0] ef; string t;
          ea = q_addr.pop_front(); ef = q_fault.pop_front(); t = q_tag.pop_front();
          check(out_addr == ea, {t, " address"}, out_addr, ea);
          check(out_fault == ef, {t, " fault"}, {62'h0, out_fault}, {62'h0, ef});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0, "R11 out_valid in reset", {63'h0, out_valid}, 64'h0);
    check(in_ready == 1'b1, "R11 in_ready in reset", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: one-cycle latency observed directly
    base_val = 64'h40; addr_size = 2'd2; mode64 = 1'b1; in_valid = 1'b1;
    q_addr.push_back(64'h40); q_fault.push_back(2'b00); q_tag.push_back("R10 latency");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R10 valid one cycle after take", {63'h0, out_valid}, 64'h1);
    @(negedge clk);

    // R1: each scale code and a negative displacement
    for (int s = 0; s < 4; s++)
      send("R1 scale", 64'h1000, 64'h10, 2'(s), 32'hFFFF_FFFC, 64'h0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R1 positive disp", 64'h2000, 64'h3, 2'd1, 32'h7FFF_FFFF, 64'h0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2: 64-bit wrap
    send("R2 wrap64", 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 2'd0, 32'h20, 64'h0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    // R3: 32-bit and 16-bit truncation
    send("R3 trunc32", 64'h0000_0000_FFFF_FFF0, 64'h0, 2'd0, 32'h20, 64'h0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R3 trunc16", 64'h1234_5678_1234_FFFF, 64'h0, 2'd0, 32'h2, 64'h0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R4: FS/GS-type base after truncation, not truncated
    send("R4 fsgs add", 64'hFFFF_FFFF, 64'h0, 2'd0, 32'h11, 64'h0000_7000_0000_0000, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5: other segment base ignored in 64-bit mode
    send("R5 base ignored", 64'h5000, 64'h0, 2'd0, 32'h0, 64'h1234_0000_0000, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: canonical edges and a general-protection fault
    send("R6 upper canonical", 64'hFFFF_8000_0000_0000, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R6 lower canonical", 64'h0000_7FFF_FFFF_FFFF, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R6 gp fault", 64'h0000_8000_0000_0000, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    // R4 with R6: carry into bit 47 from the late segment add
    send("R4 R6 fsgs carry", 64'hFFFF_FFF0, 64'h0, 2'd0, 32'h0, 64'h0000_7FFF_FFFF_FFF0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7: stack fault kinds and the override case
    send("R7 implicit stack", 64'h0000_8000_0000_0000, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    send("R7 sp base", 64'h0000_8000_0000_0000, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    send("R7 sp base override", 64'h0000_8000_0000_0000, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1);
    send("R7 fsgs carry sp base", 64'hFFFF_FFF0, 64'h0, 2'd0, 32'h0, 64'h0000_7FFF_FFFF_FFF0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    // R8: compatibility/legacy handling
    send("R8 seg wrap32", 64'h0002_0000, 64'h0, 2'd0, 32'h0, 64'hFFFF_0000, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R8 size2 as 32", 64'h1_0000_0005, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: no canonical check outside 64-bit mode
    send("R9 no fault", 64'h0000_8000_0000_0000, 64'h0, 2'd0, 32'h0, 64'hDEAD_0000_0000, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);

    // R10: back-pressure with queued requests, order kept
    stall_mode = 1'b1;
    for (int n = 0; n < 6; n++)
      send("R10 stall order", 64'h100 * (n + 1), 64'h1, 2'd3, 32'h0, 64'h0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R10 stall fault", 64'h0000_8000_0000_0000, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);

    for (int w = 0; w < 60 && q_addr.size() != 0; w++) @(negedge clk);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(q_addr.size() == 0, "R10 all results delivered", 64'(q_addr.size()), 64'h0);
    finish_run();
  end
endmodule